// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration space of one bus function. A host issues one access per clock: a read or a write of 1, 2 or 4 bytes at any byte offset. Multi-byte values are packed little-endian. Reads return their data, zero-extended to 32 bits, in the cycle after the request. Every request is accepted in the cycle it is presented.

Writes are filtered byte by byte. Which bytes are read-only depends on the header-type byte the function holds. Aligned 4-byte writes to an address-window slot (six base slots and one expansion-ROM slot) that has a nonzero size are handled differently: the stored value is aligned to the slot size and keeps either the slot's type bits or the ROM enable bit. After any write that touches the command word, and after any slot update, the block raises a one-cycle pulse so that a downstream address decoder can rebuild its map.

Parameters set the identity values, the header type, and the size and type bits of each slot. These parameters also define the reset contents.

Top module: `cfgsp_regfile`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold the vendor code and bytes 0x02-0x03 hold the device code, both low byte first. Byte 0x08 holds the revision. Bytes 0x09-0x0B hold the 24-bit class code, low byte first. Byte 0x0E holds the header type. Byte 0x10+4n holds the type bits of base slot n. Every other byte is zero.
- R2: A read with length code 0 returns 1 byte, code 1 returns 2 bytes, and code 2 or 3 returns 4 bytes. Byte offset+i goes to data bits [8i+7:8i], offsets wrap modulo 256, and the unused upper bits are zero. rsp_valid is high in exactly the cycle after the read request, and rsp_rdata is valid in that cycle.
- R3: A write that does not take the slot path (R6, R7) stores byte i of req_wdata at offset (req_addr+i) mod 256, for each byte the length covers. A read issued in the next cycle observes the new value.
- R4: With header type 0x00 or 0x80, byte-path writes leave these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D.
- R5: With any other header type, byte-path writes leave 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D unchanged. All other bytes, including 0x10-0x27 and 0x30-0x33, are writable.
- R6: A 4-byte write (length code 2 or 3) at offset 0x10+4n, for n in 0..5, where slot n has a nonzero size S stores (data AND NOT(S-1)) OR type_n.
- R7: A 4-byte write at the ROM slot offset, when the ROM size S is nonzero, stores data AND (NOT(S-1) OR 1). The ROM slot offset is 0x30 for header types 0x00 and 0x80, and 0x38 for any other header type.
- R8: A write to a slot offset whose size is zero, or one that is not an aligned 4-byte write, takes the byte path of R3-R5.
- R9: remap_req is high for exactly one cycle: the cycle after a write that covers offset 0x04 or 0x05, or after a slot-path write. It is low in every other cycle.
- R10: Reads leave the storage unchanged, and writes produce no response (rsp_valid stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Starting byte offset |
| req_len | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |
| remap_req | output | 1 | One-cycle request to rebuild the address map |

## Verification
The bench targets the following corner cases:
- A write that spans protected and open bytes, such as one that straddles the command word, or one that covers 0x3C-0x3F around the protected byte 0x3D. A design that filtered whole accesses instead of single bytes would drop or corrupt the open bytes.
- Slot writes of all ones. A design that skipped the size mask, lost the type bits, or cleared the ROM enable bit would return the wrong alignment value.
- Accesses that wrap past offset 0xFF. A design that did not wrap would write or read the wrong bytes.
- A zero-size slot, which must fall back to the protection rule.
- A second instance with bridge header type. Here the ROM sits at 0x38 and 0x30 is open, so a design with a fixed ROM offset or a fixed protection table would fail.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int CFG_BYTES = 256;
    localparam int LANES     = 4;

    typedef logic [1:0] len_code_t;

    typedef struct packed {
        logic [CFG_BYTES-1:0][7:0] mem;
        logic                      rsp_valid;
        logic [8*LANES-1:0]        rdata;
        logic                      remap;
    } cfg_state_t;

    // Number of bytes covered by a length code.
    function automatic logic [2:0] len_bytes(input len_code_t code);
        case (code)
            2'd0:    len_bytes = 3'd1;
            2'd1:    len_bytes = 3'd2;
            default: len_bytes = 3'd4;
        endcase
    endfunction

    // Header types that use the endpoint layout.
    function automatic logic is_endpoint(input logic [7:0] hdr);
        is_endpoint = (hdr == 8'h00) || (hdr == 8'h80);
    endfunction

endpackage

// File: rtl/cfgsp_wr_guard.sv
module cfgsp_wr_guard
    import cfgsp_pkg::*;
(
    input  logic [7:0] off,
    input  logic [7:0] hdr,
    output logic       writable
);
    logic locked_common;
    logic locked_layout;

    always_comb begin
        locked_common = (off <= 8'h03)
                     || (off >= 8'h08 && off <= 8'h0B)
                     || (off == 8'h0E)
                     || (off == 8'h3D);
        if (is_endpoint(hdr)) begin
            locked_layout = (off >= 8'h10 && off <= 8'h27)
                         || (off >= 8'h30 && off <= 8'h33);
        end else begin
            locked_layout = (off >= 8'h38 && off <= 8'h3B);
        end
        writable = !(locked_common || locked_layout);
    end

endmodule

// File: rtl/cfgsp_bar_mask.sv
module cfgsp_bar_mask
    import cfgsp_pkg::*;
#(
    parameter int                  NUM_SLOTS = 6,
    parameter int                  TYPE_W    = 4,
    parameter logic [NUM_SLOTS*32-1:0]     SLOT_SIZE = '0,
    parameter logic [NUM_SLOTS*TYPE_W-1:0] SLOT_TYPE = '0,
    parameter logic [31:0]         ROM_SIZE  = 32'h0
) (
    input  logic        wr_word,
    input  logic [7:0]  addr,
    input  logic [7:0]  hdr,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] masked
);
    logic [7:0]  rom_off;
    logic [31:0] size_sel;
    logic [31:0] type_sel;
    logic        bar_sel;
    logic        rom_sel;

    always_comb begin
        rom_off  = is_endpoint(hdr) ? 8'h30 : 8'h38;
        bar_sel  = 1'b0;
        size_sel = '0;
        type_sel = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (addr == 8'h10 + 8'(4 * s)) begin
                bar_sel  = 1'b1;
                size_sel = SLOT_SIZE[s*32 +: 32];
                type_sel = 32'(SLOT_TYPE[s*TYPE_W +: TYPE_W]);
            end
        end
        rom_sel = (addr == rom_off);
        if (rom_sel) begin
            size_sel = ROM_SIZE;
        end
        hit = wr_word && (bar_sel || rom_sel) && (size_sel != 32'h0);
        if (rom_sel) begin
            masked = wdata & (~(size_sel - 32'h1) | 32'h1);
        end else begin
            masked = (wdata & ~(size_sel - 32'h1)) | type_sel;
        end
    end

endmodule

// File: rtl/cfgsp_regfile.sv
module cfgsp_regfile
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h0A5F,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter int          NUM_SLOTS   = 6,
    parameter int          TYPE_W      = 4,
    parameter logic [NUM_SLOTS*32-1:0]     SLOT_SIZE =
        {32'h0, 32'h0, 32'h0, 32'h10, 32'h1000, 32'h100},
    parameter logic [NUM_SLOTS*TYPE_W-1:0] SLOT_TYPE =
        {4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1},
    parameter logic [31:0] ROM_SIZE    = 32'h800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [1:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        remap_req
);
    localparam logic [7:0] CMD_LO = 8'h04;
    localparam logic [7:0] CMD_HI = 8'h05;

    function automatic cfg_state_t reset_image();
        cfg_state_t s;
        s = '0;
        s.mem[8'h00] = VENDOR_ID[7:0];
        s.mem[8'h01] = VENDOR_ID[15:8];
        s.mem[8'h02] = DEVICE_ID[7:0];
        s.mem[8'h03] = DEVICE_ID[15:8];
        s.mem[8'h08] = REVISION_ID;
        s.mem[8'h09] = CLASS_CODE[7:0];
        s.mem[8'h0A] = CLASS_CODE[15:8];
        s.mem[8'h0B] = CLASS_CODE[23:16];
        s.mem[8'h0E] = HEADER_TYPE;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            s.mem[16 + 4*n] = 8'(SLOT_TYPE[n*TYPE_W +: TYPE_W]);
        end
        return s;
    endfunction

    localparam cfg_state_t RESET_STATE = reset_image();

    cfg_state_t q, d;

    logic [2:0]       nbytes;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_wr_ok;
    logic [7:0]       lane_off [LANES];
    logic             slot_hit;
    logic [31:0]      slot_val;

    assign nbytes = len_bytes(req_len);

    // One protection check per byte lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_off[i] = req_addr + 8'(i);
        assign lane_en[i]  = 3'(i) < nbytes;
        cfgsp_wr_guard u_guard (
            .off      (lane_off[i]),
            .hdr      (q.mem[8'h0E]),
            .writable (lane_wr_ok[i])
        );
    end

    cfgsp_bar_mask #(
        .NUM_SLOTS (NUM_SLOTS),
        .TYPE_W    (TYPE_W),
        .SLOT_SIZE (SLOT_SIZE),
        .SLOT_TYPE (SLOT_TYPE),
        .ROM_SIZE  (ROM_SIZE)
    ) u_mask (
        .wr_word (req_valid && req_write && (nbytes == 3'd4) && (req_addr[1:0] == 2'b00)),
        .addr    (req_addr),
        .hdr     (q.mem[8'h0E]),
        .wdata   (req_wdata),
        .hit     (slot_hit),
        .masked  (slot_val)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.remap     = 1'b0;
        if (req_valid && !req_write) begin
            d.rsp_valid = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                d.rdata[8*i +: 8] = lane_en[i] ? q.mem[lane_off[i]] : 8'h00;
            end
        end else if (req_valid && slot_hit) begin
            for (int i = 0; i < LANES; i++) begin
                d.mem[lane_off[i]] = slot_val[8*i +: 8];
            end
            d.remap = 1'b1;
        end else if (req_valid) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_en[i] && lane_wr_ok[i]) begin
                    d.mem[lane_off[i]] = req_wdata[8*i +: 8];
                end
                if (lane_en[i] && (lane_off[i] == CMD_LO || lane_off[i] == CMD_HI)) begin
                    d.remap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rdata;
    assign remap_req = q.remap;

    // R2: a read is answered in the following cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R10: no response without a read
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R2: single-byte reads are zero-extended
    a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_len == 2'd0) |=> (rsp_rdata[31:8] == 24'h0));

    // R9: a write overlapping the command word requests a remap
    a_r9_cmd_remap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && ({1'b0, req_addr} <= 9'd5)
         && ({1'b0, req_addr} + 9'(nbytes) > 9'd4)) |=> remap_req);

    // R9: the remap pulse does not persist without a new write
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_req && !(req_valid && req_write)) |=> !remap_req);

    // R4: identity bytes never change after reset
    a_r4_ids_locked: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(q.mem[3:0]));

    // R6: a sized endpoint slot always keeps its type bits
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        if (is_endpoint(HEADER_TYPE) && SLOT_SIZE[s*32 +: 32] != 32'h0
            && SLOT_TYPE[s*TYPE_W +: TYPE_W] != '0) begin : g_on
            a_r6_type_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (q.mem[16 + 4*s][TYPE_W-1:0] & SLOT_TYPE[s*TYPE_W +: TYPE_W])
                    == SLOT_TYPE[s*TYPE_W +: TYPE_W]);
        end
    end

endmodule

// File: tb/cfgsp_regfile_tb.sv
module cfgsp_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        va = 1'b0, vb = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rv_a, rv_b, rm_a, rm_b;
    logic [31:0] rd_a, rd_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    cfgsp_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(va), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rv_a), .rsp_rdata(rd_a), .remap_req(rm_a)
    );

    cfgsp_regfile #(.HEADER_TYPE(8'h01)) u_dut_br (
        .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rv_b), .rsp_rdata(rd_b), .remap_req(rm_b)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [1:0]  len;
        logic [31:0] wdata;
        logic [31:0] exp;   // read data, or expected remap for writes
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 2'd2, 32'h0,        32'h0A5FC0DE, 4'd1},  // R1 ids
        '{1'b0, 8'h08, 2'd2, 32'h0,        32'h02000003, 4'd1},  // R1 rev/class
        '{1'b0, 8'h10, 2'd0, 32'h0,        32'h00000001, 4'd1},  // R1 slot type
        '{1'b0, 8'h02, 2'd1, 32'h0,        32'h00000A5F, 4'd2},  // R2 half
        '{1'b1, 8'h00, 2'd2, 32'hFFFFFFFF, 32'h0,        4'd4},  // R4 ids locked
        '{1'b0, 8'h00, 2'd2, 32'h0,        32'h0A5FC0DE, 4'd4},
        '{1'b1, 8'h04, 2'd1, 32'h00000107, 32'h1,        4'd9},  // R9 command
        '{1'b0, 8'h04, 2'd1, 32'h0,        32'h00000107, 4'd3},  // R3
        '{1'b1, 8'h3C, 2'd2, 32'h11223344, 32'h0,        4'd4},  // R4 0x3D locked
        '{1'b0, 8'h3C, 2'd2, 32'h0,        32'h11220044, 4'd4},
        '{1'b1, 8'h10, 2'd2, 32'h12345678, 32'h1,        4'd6},  // R6 slot 0
        '{1'b0, 8'h10, 2'd2, 32'h0,        32'h12345601, 4'd6},
        '{1'b1, 8'h18, 2'd2, 32'hFFFFFFFF, 32'h1,        4'd6},  // R6 slot 2
        '{1'b0, 8'h18, 2'd2, 32'h0,        32'hFFFFFFF8, 4'd6},
        '{1'b1, 8'h1C, 2'd2, 32'hDEADBEEF, 32'h0,        4'd8},  // R8 zero size
        '{1'b0, 8'h1C, 2'd2, 32'h0,        32'h00000000, 4'd8},
        '{1'b1, 8'h11, 2'd0, 32'h000000AA, 32'h0,        4'd8},  // R8 byte path
        '{1'b0, 8'h10, 2'd2, 32'h0,        32'h12345601, 4'd8},
        '{1'b1, 8'h30, 2'd2, 32'hFFFFFFFF, 32'h1,        4'd7},  // R7 rom
        '{1'b0, 8'h30, 2'd2, 32'h0,        32'hFFFFF801, 4'd7},
        '{1'b1, 8'h03, 2'd1, 32'h000055AA, 32'h1,        4'd9},  // R9 straddle
        '{1'b0, 8'h04, 2'd2, 32'h0,        32'h00000155, 4'd3},
        '{1'b1, 8'hFE, 2'd2, 32'hA1B2C3D4, 32'h0,        4'd3},  // R3 wrap
        '{1'b0, 8'hFE, 2'd1, 32'h0,        32'h0000C3D4, 4'd3},
        '{1'b0, 8'hFF, 2'd3, 32'h0,        32'h5FC0DEC3, 4'd2},  // R2 wrap, code 3
        '{1'b1, 8'h40, 2'd0, 32'h00000077, 32'h0,        4'd3},
        '{1'b0, 8'h40, 2'd0, 32'h0,        32'h00000077, 4'd10}, // R10 read
        '{1'b0, 8'h40, 2'd0, 32'h0,        32'h00000077, 4'd10},
        '{1'b1, 8'h06, 2'd2, 32'hFFFF0000, 32'h0,        4'd9},  // R9 no overlap
        '{1'b0, 8'h08, 2'd2, 32'h0,        32'h02000003, 4'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input bit br, input logic wr, input logic [7:0] a,
                      input logic [1:0] l, input logic [31:0] wd);
        req_write = wr;
        req_addr  = a;
        req_len   = l;
        req_wdata = wd;
        va = !br;
        vb = br;
        @(negedge clk);
        va = 1'b0;
        vb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rsp_valid", {31'b0, rv_a}, 32'h0);
        chk("R1 reset remap", {31'b0, rm_a}, 32'h0);
        chk("R1 reset bridge rsp_valid", {31'b0, rv_b}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            op(1'b0, VECS[k].wr, VECS[k].addr, VECS[k].len, VECS[k].wdata);
            if (VECS[k].wr) begin
                chk($sformatf("R%0d vec %0d remap", VECS[k].req, k), {31'b0, rm_a}, VECS[k].exp);
                chk($sformatf("R10 vec %0d no rsp", k), {31'b0, rv_a}, 32'h0);
            end else begin
                chk($sformatf("R%0d vec %0d rdata", VECS[k].req, k), rd_a, VECS[k].exp);
                chk($sformatf("R2 vec %0d rsp_valid", k), {31'b0, rv_a}, 32'h1);
            end
        end

        // R9: pulse lasts one cycle
        op(1'b0, 1'b1, 8'h05, 2'd0, 32'h3);
        chk("R9 pulse high", {31'b0, rm_a}, 32'h1);
        @(negedge clk);
        chk("R9 pulse drops", {31'b0, rm_a}, 32'h0);

        // Bridge header instance: R1, R5, R7, R8
        op(1'b1, 1'b0, 8'h0E, 2'd0, 32'h0);
        chk("R1 bridge header byte", rd_b, 32'h01);
        op(1'b1, 1'b1, 8'h38, 2'd2, 32'hFFFFFFFF);
        chk("R7 bridge rom remap", {31'b0, rm_b}, 32'h1);
        op(1'b1, 1'b0, 8'h38, 2'd2, 32'h0);
        chk("R7 bridge rom value", rd_b, 32'hFFFFF801);
        op(1'b1, 1'b1, 8'h39, 2'd0, 32'h0);
        chk("R5 bridge rom byte no remap", {31'b0, rm_b}, 32'h0);
        op(1'b1, 1'b0, 8'h38, 2'd2, 32'h0);
        chk("R5 bridge rom byte locked", rd_b, 32'hFFFFF801);
        op(1'b1, 1'b1, 8'h30, 2'd0, 32'h5A);
        op(1'b1, 1'b0, 8'h30, 2'd0, 32'h0);
        chk("R5 bridge 0x30 open", rd_b, 32'h5A);
        op(1'b1, 1'b1, 8'h1C, 2'd2, 32'h11223344);
        chk("R8 bridge zero-size no remap", {31'b0, rm_b}, 32'h0);
        op(1'b1, 1'b0, 8'h1C, 2'd2, 32'h0);
        chk("R8 bridge zero-size byte path", rd_b, 32'h11223344);
        op(1'b1, 1'b1, 8'h09, 2'd0, 32'hEE);
        op(1'b1, 1'b0, 8'h08, 2'd2, 32'h0);
        chk("R5 bridge class locked", rd_b, 32'h02000003);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule